// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a binary up-counter assembled from 4-bit slices. Every bit of the count changes together on the rising clock edge. An active-low clear and an active-low parallel load both act on the edge and take precedence over counting. Counting needs two enables. The carry enable alone also gates a combinational ripple-carry output, so a slice can enable the slice above it with no extra gating.

The top level chains a parameterised number of slices. Each slice's carry enable comes from the ripple-carry of the slice below it, so the chain behaves as one register of width 4 times the slice count. An optional terminal-count decoder compares the count against a programmed value. When the two match, it drives the synchronous clear, which shortens the count cycle to a chosen modulus. An active-low asynchronous reset sets the count to zero.

Top module: `cascade_counter`

## Requirements
- R1: While rst_ni is low, q_o is 0 at once, without waiting for a clock edge.
- R2: When clr_ni is low at a rising edge, q_o becomes 0, whatever the levels of load_ni, enp_i and ent_i. Clear wins over load.
- R3: When clr_ni is high and load_ni is low at a rising edge, q_o takes data_i, whatever the enables are. No count happens on that edge.
- R4: With clr_ni and load_ni high, q_o increments by one at an edge only if enp_i and ent_i are both high, and otherwise holds. Changing an enable between edges does not change q_o.
- R5: The count wraps from all ones to 0 and leaves no overflow flag.
- R6: rco_o is high exactly when ent_i is high and every bit of q_o is 1. It follows these signals combinationally and does not depend on enp_i.
- R7: With NSLICES slices, q_o counts exactly like a single binary register of width 4*NSLICES, with carries passing across slice boundaries on the same edge.
- R8: When term_en_i is high and q_o equals term_i at a rising edge, q_o becomes 0 on that edge, whatever the enables are. When term_en_i is low, term_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Synchronous clear, active low |
| load_ni | input | 1 | Synchronous parallel load, active low |
| enp_i | input | 1 | Count enable, does not gate the carry |
| ent_i | input | 1 | Count enable that also gates rco_o |
| data_i | input | 4*NSLICES | Parallel load value |
| term_en_i | input | 1 | Enables the terminal-count clear |
| term_i | input | 4*NSLICES | Terminal count that triggers the clear |
| q_o | output | 4*NSLICES | Count value |
| rco_o | output | 1 | Ripple-carry: ent_i and count at maximum |

## Verification
Clear, load, count, hold and terminal-count results reach q_o one rising edge after the inputs are applied. rco_o is valid in the same cycle as the count and the ent_i that produce it, and reset acts on q_o immediately. The bench changes inputs only on falling edges. It samples 1 ns after the next rising edge, when the new count and its ripple-carry are both settled and the inputs have not yet moved. A separate check samples between edges after an enable change, to show that such a change cannot alter the count.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int unsigned SLICE_W = 4;
endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_ni,
  input  logic               load_ni,
  input  logic               enp_i,
  input  logic               ent_i,
  input  logic [SLICE_W-1:0] data_i,
  output logic [SLICE_W-1:0] q_o,
  output logic               rco_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= '0;
    else if (!clr_ni)           q_o <= '0;
    else if (!load_ni)          q_o <= data_i;
    else if (enp_i && ent_i)    q_o <= q_o + 1'b1;
  end

  assign rco_o = ent_i & (&q_o);

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> q_o == '0);
  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !load_ni |=> q_o == $past(data_i));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && !(enp_i && ent_i) |=> $stable(q_o));
  p_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && enp_i && ent_i |=> q_o == SLICE_W'($past(q_o) + 1'b1));

endmodule

// File: rtl/term_decode.sv
module term_decode #(
  parameter int unsigned W = 8
) (
  input  logic         clr_ni,
  input  logic         term_en_i,
  input  logic [W-1:0] term_i,
  input  logic [W-1:0] q_i,
  output logic         clr_no
);

  logic hit;
  assign hit    = term_en_i && (q_i == term_i);
  assign clr_no = clr_ni & ~hit;

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int unsigned NSLICES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_ni,
  input  logic                         load_ni,
  input  logic                         enp_i,
  input  logic                         ent_i,
  input  logic [SLICE_W*NSLICES-1:0]   data_i,
  input  logic                         term_en_i,
  input  logic [SLICE_W*NSLICES-1:0]   term_i,
  output logic [SLICE_W*NSLICES-1:0]   q_o,
  output logic                         rco_o
);

  localparam int unsigned W = SLICE_W * NSLICES;

  logic             clr_eff_n;
  logic [NSLICES:0] carry;

  term_decode #(.W(W)) i_term_decode (
    .clr_ni    (clr_ni),
    .term_en_i (term_en_i),
    .term_i    (term_i),
    .q_i       (q_o),
    .clr_no    (clr_eff_n)
  );

  assign carry[0] = ent_i;

  for (genvar k = 0; k < NSLICES; k++) begin : g_slice
    cnt_slice i_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_ni  (clr_eff_n),
      .load_ni (load_ni),
      .enp_i   (enp_i),
      .ent_i   (carry[k]),
      .data_i  (data_i[k*SLICE_W +: SLICE_W]),
      .q_o     (q_o[k*SLICE_W +: SLICE_W]),
      .rco_o   (carry[k+1])
    );
  end

  assign rco_o = carry[NSLICES];

  p_wide_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_eff_n && load_ni && enp_i && ent_i |=> q_o == W'($past(q_o) + 1'b1));
  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rco_o && enp_i && clr_ni && load_ni |=> q_o == '0);
  p_rco_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ent_i |-> !rco_o);
  p_term_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_en_i && (q_o == term_i) |=> q_o == '0);

endmodule

// File: tb/test_cascade_counter.sv
module test_cascade_counter;
  localparam int unsigned NS = 2;
  localparam int unsigned W  = 4 * NS;
  localparam int unsigned NV = 21;
  localparam int unsigned VW = 5 + 3 * W + 1;

  logic         clk_i = 1'b0;
  logic         rst_ni, clr_ni, load_ni, enp_i, ent_i, term_en_i;
  logic [W-1:0] data_i, term_i, q_o;
  logic         rco_o;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #5 clk_i = ~clk_i;

  cascade_counter #(.NSLICES(NS)) i_cascade_counter (
    .clk_i, .rst_ni, .clr_ni, .load_ni, .enp_i, .ent_i, .data_i,
    .term_en_i, .term_i, .q_o, .rco_o
  );

  // {clr_n, load_n, enp, ent, term_en, data, term, exp_q, exp_rco}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,1'b1,1'b0,8'h55,8'h00,8'h00,1'b0},
    {1'b1,1'b0,1'b0,1'b0,1'b0,8'hFC,8'h00,8'hFC,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,8'hFD,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,8'hFE,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,8'hFF,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,8'h00,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,8'h01,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,8'h02,1'b0},
    {1'b1,1'b1,1'b0,1'b1,1'b0,8'h00,8'h00,8'h02,1'b0},
    {1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,8'h02,1'b0},
    {1'b1,1'b0,1'b1,1'b1,1'b0,8'h0F,8'h00,8'h0F,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,8'h10,1'b0},
    {1'b1,1'b0,1'b0,1'b1,1'b0,8'hFF,8'h00,8'hFF,1'b1},
    {1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'hFF,1'b0},
    {1'b1,1'b0,1'b0,1'b0,1'b0,8'h02,8'h00,8'h02,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b1,8'h00,8'h03,8'h03,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b1,8'h00,8'h03,8'h00,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,8'h01,8'h01,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,8'h01,8'h02,1'b0},
    {1'b1,1'b0,1'b0,1'b0,1'b0,8'h07,8'h00,8'h07,1'b0},
    {1'b1,1'b1,1'b0,1'b0,1'b1,8'h00,8'h07,8'h00,1'b0}
  };

  function automatic string tag_of(int i);
    case (i)
      0:              return "R2";
      1, 10, 14, 19:  return "R3";
      4, 12, 13:      return "R6";
      5:              return "R5";
      11:             return "R7";
      15, 16, 17, 18, 20: return "R8";
      default:        return "R4";
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] model;
    rst_ni = 1'b0; clr_ni = 1'b1; load_ni = 1'b1; enp_i = 1'b0; ent_i = 1'b1;
    term_en_i = 1'b0; data_i = '0; term_i = '0;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R1 reset q", q_o, '0);
    chk("R1 reset rco", W'(rco_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk_i);
      {clr_ni, load_ni, enp_i, ent_i, term_en_i, data_i, term_i} = v[VW-1:W+1];
      @(posedge clk_i);
      #1;
      chk($sformatf("%s row %0d q", tag_of(i), i), q_o, v[W:1]);
      chk($sformatf("%s row %0d rco", tag_of(i), i), W'(rco_o), W'(v[0]));
    end

    // R4: enable change between edges leaves q alone until the edge
    @(negedge clk_i);
    clr_ni = 1'b1; load_ni = 1'b0; data_i = 8'h40; enp_i = 1'b0; ent_i = 1'b0; term_en_i = 1'b0;
    @(negedge clk_i);
    load_ni = 1'b1; enp_i = 1'b1; ent_i = 1'b1;
    #2;
    chk("R4 mid-cycle enable", q_o, 8'h40);
    @(posedge clk_i);
    #1;
    chk("R4 count after edge", q_o, 8'h41);

    // R2: clear wins over load with enables low
    @(negedge clk_i);
    clr_ni = 1'b0; load_ni = 1'b0; data_i = 8'hAA; enp_i = 1'b0; ent_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk("R2 clear over load", q_o, '0);

    // R7/R5: long free run against a wide model
    @(negedge clk_i);
    clr_ni = 1'b1; load_ni = 1'b1; enp_i = 1'b1; ent_i = 1'b1;
    model = '0;
    for (int c = 0; c < 300; c++) begin
      @(posedge clk_i);
      #1;
      model = model + 1'b1;
      chk("R7 wide count", q_o, model);
      chk("R5 wrap rco", W'(rco_o), W'(model == '1));
    end

    // R1: asynchronous reset between edges
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", q_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule